// File: doc/BRIEF.md
# Exception vector and cause generator

This block turns a one-cycle exception request into everything the processor needs to start the handler. It produces the handler address, the exception return address, the 5-bit cause code, the branch-delay flag and the new exception-level bit. When the request is a memory-management fault, it also produces new values for the fault-address side registers: the bad virtual address, the page-table context and the entry-high tag.

The requester gives an exception kind. For memory faults it also gives a fault class and an access direction. Alongside these come the current PC, a delay-slot flag, the boot-vector, exception-level and interrupt-vector status bits, the aligned part of the exception base register, the faulting address, the upper part of the current context register and the current address-space ID. All results are registered on the clock edge that samples the request. They then hold until the next accepted request.

Top module: `exc_vector_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every output to zero.
- R2: `exc_done` is high for exactly the one cycle after the edge that samples `req_valid` with a listed kind. All other outputs change only on such an edge.
- R3: The cause code is set by the kind code: interrupt (0) gives 0, instruction bus error (2) gives 6, data bus error (3) gives 7, syscall (4) gives 8, break (5) gives 9, reserved instruction (6) gives 10, coprocessor unusable (7) gives 11, overflow (8) gives 12, trap (9) gives 13, floating point (10) gives 15, cache error (11) gives 30.
- R4: A memory fault (kind 1) sets the cause from `fault_class` and `fault_store`. Class 0 (bad address) gives 5 for a store and 4 for a load. Class 1 (no match) and class 2 (invalid) give 3 for a store and 2 for a load. Class 3 (dirty) gives 1.
- R5: The vector base is `BOOT_VEC` (0xBFC00200) when `st_bev` is 1. Otherwise it is `exc_base` followed by ten zero bits.
- R6: The handler address is the base plus an offset, which is 0x180 by default. It is 0x200 for an interrupt with `cause_iv` set. It is 0x000 for a no-match memory fault with `st_exl` clear. A no-match fault with `st_exl` set uses 0x180, and so does an invalid fault.
- R7: A cache error uses offset 0x100 when `st_bev` is 1 and 0x20000100 otherwise.
- R8: With `st_exl` clear, the return address is `cur_pc`−4 and `cause_bd` is set when `in_dslot` is 1. When `in_dslot` is 0, the return address is `cur_pc` and `cause_bd` is cleared.
- R9: With `st_exl` set, the return address and `cause_bd` keep their previous values. In every accepted case, `exl_next` becomes 1.
- R10: On a memory fault, `bad_vaddr` takes the full fault address. `context_next` takes `ctx_hi` in bits 31:23, address bits 31:13 in bits 22:4 and zero in bits 3:0. `entry_hi_next` takes address bits 31:13 in bits 31:13, zero in bits 12:8 and `cur_asid` in bits 7:0. For any other kind, all three hold.
- R11: A request with kind code 12 to 15 is ignored: `exc_done` stays low and every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle exception request |
| req_kind | input | 4 | Exception kind code |
| fault_class | input | 2 | Memory fault class (kind 1 only) |
| fault_store | input | 1 | 1 = store access, 0 = load |
| cur_pc | input | 32 | PC of the excepting instruction |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| st_bev | input | 1 | Boot-vector status bit |
| st_exl | input | 1 | Exception-level status bit |
| cause_iv | input | 1 | Interrupt-vector bit |
| exc_base | input | 22 | Exception base register bits 31:10 |
| fault_addr | input | 32 | Faulting virtual address |
| ctx_hi | input | 9 | Current context register bits 31:23 |
| cur_asid | input | 8 | Current address-space ID |
| exc_done | output | 1 | Results updated last edge |
| next_pc | output | 32 | Handler address |
| epc | output | 32 | Exception return address |
| cause_code | output | 5 | Exception cause code |
| cause_bd | output | 1 | Branch-delay flag |
| exl_next | output | 1 | New exception-level bit |
| bad_vaddr | output | 32 | Bad virtual address |
| context_next | output | 32 | New context register |
| entry_hi_next | output | 32 | New entry-high register |

## Verification
The hardest case is the refill offset. It needs a no-match memory fault while `st_exl` is clear. The same fault with `st_exl` set, and an invalid fault, must both fall back to 0x180. The stimulus sweeps every kind and every fault class against both boot-vector settings, both exception-level settings, both delay-slot settings and both interrupt-vector settings. A behavioural model in the bench tracks the held return address and the held side registers. That model exposes any update that leaks when `st_exl` is set or when a non-memory kind arrives.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    localparam int CAUSE_W = 5;
    localparam int KIND_W  = 4;

    typedef enum logic [KIND_W-1:0] {
        EK_INTR = 4'd0,
        EK_MEMF = 4'd1,
        EK_IBUS = 4'd2,
        EK_DBUS = 4'd3,
        EK_SYSC = 4'd4,
        EK_BRK  = 4'd5,
        EK_RSVD = 4'd6,
        EK_COPU = 4'd7,
        EK_OVFL = 4'd8,
        EK_TRAP = 4'd9,
        EK_FPEX = 4'd10,
        EK_CERR = 4'd11
    } exc_kind_e;

    typedef enum logic [1:0] {
        MF_BADADDR = 2'd0,
        MF_NOMATCH = 2'd1,
        MF_INVALID = 2'd2,
        MF_DIRTY   = 2'd3
    } mem_fault_e;

    typedef enum logic [1:0] {
        VO_GENERAL,
        VO_REFILL,
        VO_INTVEC,
        VO_CACHE
    } vec_sel_e;

    typedef struct packed {
        logic               legal;
        logic [CAUSE_W-1:0] code;
        vec_sel_e           vsel;
        logic               mmu_upd;
    } exc_class_t;

    localparam logic [31:0] OFF_GENERAL  = 32'h0000_0180;
    localparam logic [31:0] OFF_REFILL   = 32'h0000_0000;
    localparam logic [31:0] OFF_INTVEC   = 32'h0000_0200;
    localparam logic [31:0] OFF_CACHE_BT = 32'h0000_0100;
    localparam logic [31:0] OFF_CACHE_RN = 32'h2000_0100;

    function automatic logic [CAUSE_W-1:0] mem_cause(mem_fault_e c, logic st);
        case (c)
            MF_BADADDR: return st ? 5'd5 : 5'd4;
            MF_DIRTY:   return 5'd1;
            default:    return st ? 5'd3 : 5'd2;
        endcase
    endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_vec_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [1:0]        fclass,
    input  logic              fstore,
    input  logic              exl,
    input  logic              iv,
    output exc_class_t        cls
);
    always_comb begin
        cls = '{legal: 1'b1, code: '0, vsel: VO_GENERAL, mmu_upd: 1'b0};
        case (kind)
            EK_INTR: cls.vsel = iv ? VO_INTVEC : VO_GENERAL;
            EK_MEMF: begin
                cls.code    = mem_cause(mem_fault_e'(fclass), fstore);
                cls.mmu_upd = 1'b1;
                if (mem_fault_e'(fclass) == MF_NOMATCH && !exl)
                    cls.vsel = VO_REFILL;
            end
            EK_IBUS: cls.code = 5'd6;
            EK_DBUS: cls.code = 5'd7;
            EK_SYSC: cls.code = 5'd8;
            EK_BRK:  cls.code = 5'd9;
            EK_RSVD: cls.code = 5'd10;
            EK_COPU: cls.code = 5'd11;
            EK_OVFL: cls.code = 5'd12;
            EK_TRAP: cls.code = 5'd13;
            EK_FPEX: cls.code = 5'd15;
            EK_CERR: begin
                cls.code = 5'd30;
                cls.vsel = VO_CACHE;
            end
            default: cls.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/exc_vector_calc.sv
module exc_vector_calc
    import exc_vec_pkg::*;
#(
    parameter logic [31:0] BOOT_VEC = 32'hBFC0_0200,
    parameter int          ALIGN_W  = 10
)(
    input  logic                  bev,
    input  logic [31-ALIGN_W:0]   ebase,
    input  vec_sel_e              vsel,
    output logic [31:0]           vec
);
    logic [31:0] base;
    logic [31:0] offset;

    always_comb begin
        base = bev ? BOOT_VEC : {ebase, {ALIGN_W{1'b0}}};
        case (vsel)
            VO_REFILL: offset = OFF_REFILL;
            VO_INTVEC: offset = OFF_INTVEC;
            VO_CACHE:  offset = bev ? OFF_CACHE_BT : OFF_CACHE_RN;
            default:   offset = OFF_GENERAL;
        endcase
        vec = base + offset;
    end
endmodule

// File: rtl/exc_mmu_regs.sv
module exc_mmu_regs #(
    parameter int ASID_W  = 8,
    parameter int PAGE_LO = 13,
    parameter int CTX_LO  = 23
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  logic [31:0]         faddr,
    input  logic [31-CTX_LO:0]  ctx_hi,
    input  logic [ASID_W-1:0]   asid,
    output logic [31:0]         bad_vaddr,
    output logic [31:0]         context_next,
    output logic [31:0]         entry_hi_next
);
    localparam int VPN_W = 32 - PAGE_LO;
    localparam int CTX_PAD = CTX_LO - VPN_W;
    localparam int EHI_PAD = PAGE_LO - ASID_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_vaddr     <= '0;
            context_next  <= '0;
            entry_hi_next <= '0;
        end else if (upd) begin
            bad_vaddr     <= faddr;
            context_next  <= {ctx_hi, faddr[31:PAGE_LO], {CTX_PAD{1'b0}}};
            entry_hi_next <= {faddr[31:PAGE_LO], {EHI_PAD{1'b0}}, asid};
        end
    end

    p_side_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(bad_vaddr) && $stable(context_next) && $stable(entry_hi_next)));

    p_side_load_r10: assert property (@(posedge clk) disable iff (rst)
        upd |=> (bad_vaddr == $past(faddr) && entry_hi_next[ASID_W-1:0] == $past(asid)));
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
    import exc_vec_pkg::*;
#(
    parameter logic [31:0] BOOT_VEC = 32'hBFC0_0200
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [3:0]   req_kind,
    input  logic [1:0]   fault_class,
    input  logic         fault_store,
    input  logic [31:0]  cur_pc,
    input  logic         in_dslot,
    input  logic         st_bev,
    input  logic         st_exl,
    input  logic         cause_iv,
    input  logic [21:0]  exc_base,
    input  logic [31:0]  fault_addr,
    input  logic [8:0]   ctx_hi,
    input  logic [7:0]   cur_asid,
    output logic         exc_done,
    output logic [31:0]  next_pc,
    output logic [31:0]  epc,
    output logic [4:0]   cause_code,
    output logic         cause_bd,
    output logic         exl_next,
    output logic [31:0]  bad_vaddr,
    output logic [31:0]  context_next,
    output logic [31:0]  entry_hi_next
);
    exc_class_t  cls;
    logic [31:0] vec;
    logic        take;

    exc_classify u_cls (
        .kind(req_kind), .fclass(fault_class), .fstore(fault_store),
        .exl(st_exl), .iv(cause_iv), .cls(cls)
    );

    exc_vector_calc #(.BOOT_VEC(BOOT_VEC), .ALIGN_W(10)) u_vec (
        .bev(st_bev), .ebase(exc_base), .vsel(cls.vsel), .vec(vec)
    );

    assign take = req_valid && cls.legal;

    exc_mmu_regs #(.ASID_W(8), .PAGE_LO(13), .CTX_LO(23)) u_mmu (
        .clk(clk), .rst(rst), .upd(take && cls.mmu_upd),
        .faddr(fault_addr), .ctx_hi(ctx_hi), .asid(cur_asid),
        .bad_vaddr(bad_vaddr), .context_next(context_next),
        .entry_hi_next(entry_hi_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_done   <= 1'b0;
            next_pc    <= '0;
            epc        <= '0;
            cause_code <= '0;
            cause_bd   <= 1'b0;
            exl_next   <= 1'b0;
        end else begin
            exc_done <= take;
            if (take) begin
                next_pc    <= vec;
                cause_code <= cls.code;
                exl_next   <= 1'b1;
                if (!st_exl) begin
                    epc      <= in_dslot ? cur_pc - 32'd4 : cur_pc;
                    cause_bd <= in_dslot;
                end
            end
        end
    end

    p_done_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        exc_done |-> $past(req_valid));

    p_exl_set_r9: assert property (@(posedge clk) disable iff (rst)
        exc_done |-> exl_next);

    p_epc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && st_exl) |=> ($stable(epc) && $stable(cause_bd)));

    p_vec_offset_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !st_bev) |=> (!exc_done || next_pc[9:0] == 10'h000 ||
            next_pc[9:0] == 10'h100 || next_pc[9:0] == 10'h180 || next_pc[9:0] == 10'h200));

    p_bad_kind_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind >= 4'd12) |=> !exc_done);
endmodule

// File: tb/exc_vector_unit_tb.sv
module exc_vector_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [3:0] req_kind = '0;
    logic [1:0] fault_class = '0;
    logic fault_store = 1'b0;
    logic [31:0] cur_pc = '0;
    logic in_dslot = 1'b0, st_bev = 1'b0, st_exl = 1'b0, cause_iv = 1'b0;
    logic [21:0] exc_base = '0;
    logic [31:0] fault_addr = '0;
    logic [8:0] ctx_hi = '0;
    logic [7:0] cur_asid = '0;
    logic exc_done, cause_bd, exl_next;
    logic [31:0] next_pc, epc, bad_vaddr, context_next, entry_hi_next;
    logic [4:0] cause_code;

    exc_vector_unit u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit finished = 0;

    // reference model state
    logic        m_done, m_bd, m_exl;
    logic [31:0] m_pc, m_epc, m_bva, m_ctx, m_ehi;
    logic [4:0]  m_code;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_done = 0; m_bd = 0; m_exl = 0; m_pc = 0; m_epc = 0;
            m_bva = 0; m_ctx = 0; m_ehi = 0; m_code = 0;
        end else if (req_valid && req_kind <= 4'd11) begin
            logic [31:0] base, off;
            base = st_bev ? 32'hBFC00200 : {exc_base, 10'd0};
            off = 32'h180;
            case (req_kind)
                4'd0: begin m_code = 0; if (cause_iv) off = 32'h200; end
                4'd1: begin
                    if (fault_class == 2'd0) m_code = fault_store ? 5'd5 : 5'd4;
                    else if (fault_class == 2'd3) m_code = 5'd1;
                    else m_code = fault_store ? 5'd3 : 5'd2;
                    if (fault_class == 2'd1 && !st_exl) off = 0;
                    m_bva = fault_addr;
                    m_ctx = ({23'd0, ctx_hi} << 23) | ((fault_addr >> 9) & 32'h007FFFF0);
                    m_ehi = (fault_addr & 32'hFFFFE000) | {24'd0, cur_asid};
                end
                4'd10: m_code = 5'd15;
                4'd11: begin
                    m_code = 5'd30;
                    off = st_bev ? 32'h100 : 32'h20000100;
                end
                default: m_code = 5'({1'b0, req_kind} + 5'd4);
            endcase
            m_pc = base + off;
            m_exl = 1;
            if (!st_exl) begin
                m_epc = in_dslot ? cur_pc - 4 : cur_pc;
                m_bd = in_dslot;
            end
            m_done = 1;
        end else begin
            m_done = 0;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R2 exc_done", {31'd0, exc_done}, {31'd0, m_done});
            chk("R5 R6 R7 next_pc", next_pc, m_pc);
            chk("R8 R9 epc", epc, m_epc);
            chk("R3 R4 cause_code", {27'd0, cause_code}, {27'd0, m_code});
            chk("R8 cause_bd", {31'd0, cause_bd}, {31'd0, m_bd});
            chk("R9 exl_next", {31'd0, exl_next}, {31'd0, m_exl});
            chk("R10 bad_vaddr", bad_vaddr, m_bva);
            chk("R10 context_next", context_next, m_ctx);
            chk("R10 entry_hi_next", entry_hi_next, m_ehi);
        end
    end

    task automatic issue(logic [3:0] k, logic [1:0] fc, logic fs, logic ds,
                         logic bev, logic exl, logic iv);
        @(negedge clk);
        req_valid = 1; req_kind = k; fault_class = fc; fault_store = fs;
        in_dslot = ds; st_bev = bev; st_exl = exl; cause_iv = iv;
        cur_pc = $urandom & 32'hFFFFFFFC;
        exc_base = 22'($urandom);
        fault_addr = $urandom;
        ctx_hi = 9'($urandom);
        cur_asid = 8'($urandom);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
        fault_addr = $urandom;
        cur_pc = $urandom;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset next_pc", next_pc, 32'd0);
        chk("R1 reset epc", epc, 32'd0);
        chk("R1 reset exl/done/bd", {29'd0, exl_next, exc_done, cause_bd}, 32'd0);
        chk("R1 reset side regs", bad_vaddr | context_next | entry_hi_next, 32'd0);

        for (int bev = 0; bev < 2; bev++)
            for (int exl = 0; exl < 2; exl++)
                for (int ds = 0; ds < 2; ds++)
                    for (int k = 0; k < 12; k++) begin
                        if (k == 1) begin
                            for (int fc = 0; fc < 4; fc++)
                                for (int st = 0; st < 2; st++) begin
                                    issue(4'(k), 2'(fc), st[0], ds[0], bev[0], exl[0], 1'b0);
                                    idle();
                                end
                        end else if (k == 0) begin
                            for (int iv = 0; iv < 2; iv++) begin
                                issue(4'(k), 2'($urandom), 1'b0, ds[0], bev[0], exl[0], iv[0]);
                                idle();
                            end
                        end else begin
                            issue(4'(k), 2'($urandom), 1'($urandom), ds[0], bev[0], exl[0], 1'($urandom));
                            idle();
                        end
                    end

        // back-to-back requests
        for (int i = 0; i < 20; i++)
            issue(4'($urandom % 12), 2'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
        idle();
        idle();

        // R11: unlisted kinds are ignored
        for (int k = 12; k < 16; k++) begin
            issue(4'(k), 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            req_valid = 0;
            chk("R11 ignored kind exc_done", {31'd0, exc_done}, 32'd0);
            chk("R11 ignored kind epc", epc, m_epc);
        end
        idle();
        idle();

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule